// File: doc/BRIEF.md
# Partitioned SIMD equality comparator

This combinational block compares two 64-bit operands that are cut into eight byte-wide lanes. A vector of seven gate bits sets the lane boundaries at run time. The lanes between two active boundaries form one partition, and a partition can span from one to eight lanes. For each partition the block tests whether the operands match over the whole bit span of that partition. It writes the same result bit onto every lane the partition covers.

An operation select input picks the comparison. Only equality is implemented. Any other select value forces the result to zero. The result settles in the same cycle as the inputs. A SIMD datapath uses the block to compare packed vectors of bytes, half-words, words or whole double-words with one piece of hardware.

Top module: `simd_eq_cmp`

## Requirements
- R1: Lane k covers bits 8k to 8k+7 of `a_i` and `b_i`, and its result sits in bit k of `eq_o` (k = 0..7).
- R2: When bit g of `gate_i` is set, lane g and lane g+1 lie in different partitions. When it is clear, they lie in the same partition.
- R3: Every bit of `eq_o` inside a partition is 1 exactly when `a_i` equals `b_i` over every bit of that partition. All bits of one partition therefore hold the same value.
- R4: With `gate_i` all zero, all eight bits of `eq_o` equal the result of a full 64-bit equality test.
- R5: With `gate_i` all ones, bit k of `eq_o` is the equality of byte k alone.
- R6: `op_i` is 2 bits wide, and value 0 selects equality. The values 1, 2 and 3 drive `eq_o` to all zeros whatever the operands are.
- R7: `eq_o` follows its inputs with no register in between, so it is valid in the same cycle.
- R8: Partitions that do not begin at lane 0 give correct results for every width that fits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand, eight byte lanes |
| b_i | input | 64 | Second operand, eight byte lanes |
| gate_i | input | 7 | Bit g sets a boundary above lane g |
| op_i | input | 2 | Operation select, 0 = equality |
| eq_o | output | 8 | One result bit per lane |

## Verification
The assertions check these properties on every input change:
- a clear gate makes neighbouring result bits agree;
- a set result bit implies that its own byte matches;
- the all-clear gate setting reduces to a 64-bit compare;
- the all-set gate setting reduces to per-byte compares;
- a non-equality select forces zero.

Only the bench scenarios can show that each partition covers its exact bit span, because that needs a reference model. The scenarios place a single mismatching bit inside partitions of every width at offsets away from lane 0. They also check the partition edges next to that bit.

// File: rtl/simd_eq_pkg.sv
package simd_eq_pkg;
  localparam int unsigned OP_W = 2;
  localparam logic [OP_W-1:0] OP_EQ = 2'd0;
  localparam logic [OP_W-1:0] OP_GT = 2'd1;
  localparam logic [OP_W-1:0] OP_GE = 2'd2;
endpackage

// File: rtl/lane_match.sv
module lane_match #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [LANES-1:0]  match_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign match_o[k] = (a_i[k*LANE_W +: LANE_W] == b_i[k*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/part_merge.sv
module part_merge #(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES-1:0] match_i,
  input  logic [LANES-2:0] gate_i,
  output logic [LANES-1:0] res_o
);
  logic [LANES-1:0] up;

  // upward AND, restarting at each boundary
  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (i == 0) acc = match_i[i];
      else if (gate_i[i-1]) acc = match_i[i];
      else acc = acc & match_i[i];
      up[i] = acc;
    end
  end

  // downward broadcast from top lane of each partition
  always_comb begin
    logic carry;
    carry = up[LANES-1];
    res_o[LANES-1] = carry;
    for (int i = LANES - 2; i >= 0; i--) begin
      if (gate_i[i]) carry = up[i];
      res_o[i] = carry;
    end
  end
endmodule

// File: rtl/simd_eq_cmp.sv
module simd_eq_cmp
  import simd_eq_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [LANES-2:0]  gate_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [LANES-1:0]  eq_o
);
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] part_res;

  lane_match #(.LANES(LANES), .LANE_W(LANE_W)) u_match (
    .a_i(a_i), .b_i(b_i), .match_o(lane_hit)
  );

  part_merge #(.LANES(LANES)) u_merge (
    .match_i(lane_hit), .gate_i(gate_i), .res_o(part_res)
  );

  assign eq_o = (op_i == OP_EQ) ? part_res : '0;

  always_comb begin
    for (int i = 0; i < LANES - 1; i++) begin
      if (op_i == OP_EQ && !gate_i[i])
        AST_PART_UNIFORM: assert (eq_o[i] == eq_o[i+1]); // R3
    end
    for (int i = 0; i < LANES; i++)
      AST_HIT_NEEDS_LANE: assert (!eq_o[i] || lane_hit[i]); // R1
    if (op_i == OP_EQ && gate_i == '0)
      AST_FULL_WIDTH: assert (eq_o == {LANES{a_i == b_i}}); // R4
    if (op_i == OP_EQ && gate_i == '1)
      AST_PER_LANE: assert (eq_o == lane_hit); // R5
    if (op_i != OP_EQ)
      AST_OP_ZERO: assert (eq_o == '0); // R6
  end
endmodule

// File: tb/sim_simd_eq_cmp.sv
module sim_simd_eq_cmp;
  localparam int L = 8;
  localparam int W = 8;
  localparam int D = L * W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [D-1:0] a, b;
  logic [L-2:0] gate;
  logic [1:0] op;
  logic [L-1:0] eq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [L-1:0] exp; string req; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  simd_eq_cmp u0 (.a_i(a), .b_i(b), .gate_i(gate), .op_i(op), .eq_o(eq));

  function automatic logic [L-1:0] model(logic [D-1:0] x, logic [D-1:0] y,
                                         logic [L-2:0] g, logic [1:0] o);
    logic [L-1:0] r;
    r = '0;
    if (o != 2'd0) return r;
    for (int k = 0; k < L; k++) begin
      int s, e;
      logic ok;
      s = k; e = k;
      while (s > 0 && !g[s-1]) s--;
      while (e < L - 1 && !g[e]) e++;
      ok = 1'b1;
      for (int j = s; j <= e; j++)
        if (x[j*W +: W] != y[j*W +: W]) ok = 1'b0;
      r[k] = ok;
    end
    return r;
  endfunction

  task automatic drive(logic [D-1:0] x, logic [D-1:0] y, logic [L-2:0] g,
                       logic [1:0] o, string req);
    item_t it;
    @(negedge clk);
    a = x; b = y; gate = g; op = o;
    it.exp = model(x, y, g, o);
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: result must be present at the next edge (R7)
  initial begin
    forever begin
      @(posedge clk);
      if (rst_ni && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (eq !== it.exp) begin
          errors++;
          $display("FAIL %s: eq_o=%b expected=%b", it.req, eq, it.exp);
        end
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [D-1:0] base;
    a = '0; b = '0; gate = '0; op = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    base = 64'h0123_4567_89AB_CDEF;

    drive('0, '0, '0, 2'd0, "R7 reset-state");
    drive(base, base, '0, 2'd0, "R4 all equal");
    drive(base, base ^ (64'h1 << 63), '0, 2'd0, "R4 top bit diff");
    drive(base, base ^ 64'h1, '1, 2'd0, "R5 lane0 diff");
    drive(base, base ^ (64'h80 << 24), '1, 2'd0, "R1 lane3 msb diff");
    drive(base, base ^ (64'h1 << 32), 7'b000_1000, 2'd0, "R2 boundary at lane3");
    drive(base, base ^ (64'h1 << 31), 7'b000_1000, 2'd0, "R2 below boundary");
    drive(base, base ^ (64'h1 << 20), 7'b101_0101, 2'd0, "R3 mixed partitions");
    for (int o = 1; o < 4; o++)
      drive(base, base, 7'b011_0011, 2'(o), "R6 non-eq op");
    // every width w at every offset p, one bit flipped inside and just outside
    for (int w = 1; w <= L; w++) begin
      for (int p = 0; p + w <= L; p++) begin
        logic [L-2:0] g;
        g = '0;
        if (p > 0) g[p-1] = 1'b1;
        if (p + w < L) g[p+w-1] = 1'b1;
        drive(base, base ^ (64'h1 << (p*W + (w*W)/2)), g, 2'd0, "R8 inside");
        if (p + w < L)
          drive(base, base ^ (64'h1 << ((p+w)*W)), g, 2'd0, "R8 outside");
      end
    end
    for (int n = 0; n < 200; n++)
      drive({$urandom, $urandom}, {$urandom, $urandom} & 64'h0F0F_F0F0_00FF_FF00 |
            64'h0, 7'($urandom), 2'd0, "R3 random");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule